// File: doc/BRIEF.md
# Shared GPIO / Port-Status LED Pin Multiplexer

This block owns eight chip pins that each serve either as a general-purpose I/O or as a port-status LED. A per-pin LED enable bit chooses the role. In the GPIO role the pin carries the GPIO output value and output enable, and its input buffer and pull-up stay on. In the LED role the pin becomes an open-drain, active-low driver: the pad is driven low to light the LED and released to turn it off, and the input buffer and pull-up are switched off.

A two-bit display mode selects, through a fixed table, which status indication each LED pin shows. The upper four pins serve port 2 and the lower four serve port 1. The indications come from the per-port status inputs and from the host port's receive, transmit, transmit-enable and receive-data-valid signals. Some indications are combinations: link-or-activity, speed-qualified link-or-activity, and duplex-or-collision. Short activity, collision, receive and transmit pulses are stretched over a programmable period so that they are visible. The mode and the enable bits take their reset values from strap inputs and can be reloaded later through a plain load strobe. All control and status pins are level signals, so there is no stream interface and no back-pressure.

Top module: `gpio_led_mux`

## Requirements
- R1: While rst_n is low, the display mode is taken from strap_mode and the LED enables from strap_led_en. Strap changes after reset is released have no effect.
- R2: When cfg_load is high at a rising clock edge, cfg_mode and cfg_led_en replace the current mode and enables, and they take effect from that edge on.
- R3: A pin with its LED enable at 0 is a GPIO: pad_out = gpio_out, pad_oe = gpio_oe, pad_ie = 1, pad_pu = 1, and gpio_in reads pad_in.
- R4: A pin with its LED enable at 1 is an LED: pad_out = 0 at all times, pad_oe = 1 exactly when the indication is on, pad_ie = 0, pad_pu = 0, and gpio_in reads 0 for that pin.
- R5: An activity, collision, host receive or host transmit input that is high at a rising edge makes its stretched version active for the next STRETCH_CYC rising edges. A new pulse restarts the count.
- R6: Mode 0 (pins 7..0): host rx (stretched), p2 link-or-activity, p2 duplex-or-collision, p2 speed, host tx (stretched), p1 link-or-activity, p1 duplex-or-collision, p1 speed.
- R7: Mode 1: the same as mode 0, except that pins 6/2 show link-or-activity only at 100 Mb (spd100 = 1) and pins 4/0 show link-or-activity only at 10 Mb (spd100 = 0).
- R8: Mode 2 (pins 7..0): p2 stretched activity, p2 link, p2 duplex-or-collision, p2 speed, p1 stretched activity, p1 link, p1 duplex-or-collision, p1 speed.
- R9: Mode 3 (pins 7..0): off, off, p2 txen, p2 rxdv, host txen, host rxdv, p1 txen, p1 rxdv. A pin that is off stays released.
- R10: Link-or-activity is on while link is high and the stretched activity is inactive.
- R11: Duplex-or-collision is on when full duplex is high. In half duplex it is on while the stretched collision is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_mode | input | 2 | Display mode loaded during reset |
| strap_led_en | input | 8 | LED enables loaded during reset |
| cfg_load | input | 1 | Load strobe for cfg_mode and cfg_led_en |
| cfg_mode | input | 2 | New display mode |
| cfg_led_en | input | 8 | New LED enables (1 = LED role) |
| gpio_out | input | 8 | GPIO output values |
| gpio_oe | input | 8 | GPIO output enables |
| gpio_in | output | 8 | GPIO input values (0 on LED pins) |
| p1_link | input | 1 | Port 1 link up |
| p1_spd100 | input | 1 | Port 1 at 100 Mb |
| p1_fdx | input | 1 | Port 1 full duplex |
| p1_col | input | 1 | Port 1 collision pulse |
| p1_act | input | 1 | Port 1 activity pulse |
| p1_txen | input | 1 | Port 1 transmit enable |
| p1_rxdv | input | 1 | Port 1 receive data valid |
| p2_link | input | 1 | Port 2 link up |
| p2_spd100 | input | 1 | Port 2 at 100 Mb |
| p2_fdx | input | 1 | Port 2 full duplex |
| p2_col | input | 1 | Port 2 collision pulse |
| p2_act | input | 1 | Port 2 activity pulse |
| p2_txen | input | 1 | Port 2 transmit enable |
| p2_rxdv | input | 1 | Port 2 receive data valid |
| h_rx | input | 1 | Host port receive pulse |
| h_tx | input | 1 | Host port transmit pulse |
| h_txen | input | 1 | Host port transmit enable |
| h_rxdv | input | 1 | Host port receive data valid |
| pad_in | input | 8 | Pad input values |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_ie | output | 8 | Pad input buffer enables |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
The pin mapping is driven in each of the four modes with random status levels and sparse random pulses. Sparse pulses let the stretched indications both rise and expire, which separates a stretched path from a raw one and shows any miscounted period. Random LED enable masks mix GPIO and LED pins in the same cycle, which would expose a swapped role or a pull-up or input-buffer control that does not follow the role. Directed cases cover reset from the straps, straps that change after reset, a mid-run reload, and full-duplex against half-duplex with collisions.

// File: rtl/gpio_led_pkg.sv
package gpio_led_pkg;
  localparam int unsigned PIN_CNT  = 8;
  localparam int unsigned SIDE_PIN = 4;
  typedef enum logic [1:0] {
    LM_BASIC = 2'd0,
    LM_SPEED = 2'd1,
    LM_LINK  = 2'd2,
    LM_RAW   = 2'd3
  } led_mode_e;
  // stretched signal indices
  localparam int unsigned ST_P1ACT = 0;
  localparam int unsigned ST_P1COL = 1;
  localparam int unsigned ST_P2ACT = 2;
  localparam int unsigned ST_P2COL = 3;
  localparam int unsigned ST_HRX   = 4;
  localparam int unsigned ST_HTX   = 5;
  localparam int unsigned ST_CNT   = 6;
endpackage

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int unsigned STRETCH_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic active
);
  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (pulse)      cnt <= CW'(STRETCH_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);

  // R5
  pulse_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> active);
  // R5
  expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && cnt == CW'(1)) |=> !active);
endmodule

// File: rtl/led_side_map.sv
module led_side_map
  import gpio_led_pkg::*;
(
  input  led_mode_e           mode,
  input  logic                link,
  input  logic                spd100,
  input  logic                fdx,
  input  logic                col_s,
  input  logic                act_s,
  input  logic                txen,
  input  logic                rxdv,
  input  logic                host_s,
  input  logic                m3_hi,
  input  logic                m3_lnk,
  output logic [SIDE_PIN-1:0] on
);
  logic lnk_act, dup_col;
  assign lnk_act = link & ~act_s;
  assign dup_col = fdx | col_s;

  always_comb begin
    unique case (mode)
      LM_BASIC: on = {host_s, lnk_act, dup_col, spd100};
      LM_SPEED: on = {host_s, spd100 & lnk_act, dup_col, ~spd100 & lnk_act};
      LM_LINK:  on = {act_s, link, dup_col, spd100};
      default:  on = {m3_hi, m3_lnk, txen, rxdv};
    endcase
  end
endmodule

// File: rtl/gpio_led_pad.sv
module gpio_led_pad #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] led_en,
  input  logic [W-1:0] led_on,
  input  logic [W-1:0] gpio_out,
  input  logic [W-1:0] gpio_oe,
  output logic [W-1:0] gpio_in,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_ie,
  output logic [W-1:0] pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_out[i] = led_en[i] ? 1'b0      : gpio_out[i];
    assign pad_oe[i]  = led_en[i] ? led_on[i] : gpio_oe[i];
    assign pad_ie[i]  = ~led_en[i];
    assign pad_pu[i]  = ~led_en[i];
    assign gpio_in[i] = led_en[i] ? 1'b0      : pad_in[i];
  end

  // R4
  od_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & led_en) == '0));
  // R4
  led_inbuf_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((pad_ie | pad_pu | gpio_in) & led_en) == '0));
  // R3
  gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~led_en) == (gpio_oe & ~led_en)));
endmodule

// File: rtl/gpio_led_mux.sv
module gpio_led_mux
  import gpio_led_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 10_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_mode,
  input  logic [7:0] strap_led_en,
  input  logic       cfg_load,
  input  logic [1:0] cfg_mode,
  input  logic [7:0] cfg_led_en,
  input  logic [7:0] gpio_out,
  input  logic [7:0] gpio_oe,
  output logic [7:0] gpio_in,
  input  logic       p1_link,
  input  logic       p1_spd100,
  input  logic       p1_fdx,
  input  logic       p1_col,
  input  logic       p1_act,
  input  logic       p1_txen,
  input  logic       p1_rxdv,
  input  logic       p2_link,
  input  logic       p2_spd100,
  input  logic       p2_fdx,
  input  logic       p2_col,
  input  logic       p2_act,
  input  logic       p2_txen,
  input  logic       p2_rxdv,
  input  logic       h_rx,
  input  logic       h_tx,
  input  logic       h_txen,
  input  logic       h_rxdv,
  input  logic [7:0] pad_in,
  output logic [7:0] pad_out,
  output logic [7:0] pad_oe,
  output logic [7:0] pad_ie,
  output logic [7:0] pad_pu
);
  led_mode_e          mode_q;
  logic [PIN_CNT-1:0] en_q;
  logic [ST_CNT-1:0]  raw_pulse, stretched;
  logic [PIN_CNT-1:0] led_on;

  // configuration: straps during reset, load strobe afterwards
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= led_mode_e'(strap_mode);
      en_q   <= strap_led_en;
    end else if (cfg_load) begin
      mode_q <= led_mode_e'(cfg_mode);
      en_q   <= cfg_led_en;
    end
  end

  assign raw_pulse[ST_P1ACT] = p1_act;
  assign raw_pulse[ST_P1COL] = p1_col;
  assign raw_pulse[ST_P2ACT] = p2_act;
  assign raw_pulse[ST_P2COL] = p2_col;
  assign raw_pulse[ST_HRX]   = h_rx;
  assign raw_pulse[ST_HTX]   = h_tx;

  for (genvar s = 0; s < ST_CNT; s++) begin : g_st
    led_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_st (
      .clk(clk), .rst_n(rst_n), .pulse(raw_pulse[s]), .active(stretched[s])
    );
  end

  led_side_map u_map_p1 (
    .mode(mode_q), .link(p1_link), .spd100(p1_spd100), .fdx(p1_fdx),
    .col_s(stretched[ST_P1COL]), .act_s(stretched[ST_P1ACT]),
    .txen(p1_txen), .rxdv(p1_rxdv), .host_s(stretched[ST_HTX]),
    .m3_hi(h_txen), .m3_lnk(h_rxdv), .on(led_on[SIDE_PIN-1:0])
  );

  led_side_map u_map_p2 (
    .mode(mode_q), .link(p2_link), .spd100(p2_spd100), .fdx(p2_fdx),
    .col_s(stretched[ST_P2COL]), .act_s(stretched[ST_P2ACT]),
    .txen(p2_txen), .rxdv(p2_rxdv), .host_s(stretched[ST_HRX]),
    .m3_hi(1'b0), .m3_lnk(1'b0), .on(led_on[PIN_CNT-1:SIDE_PIN])
  );

  gpio_led_pad #(.W(PIN_CNT)) u_pad (
    .clk(clk), .rst_n(rst_n), .led_en(en_q), .led_on(led_on),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_ie(pad_ie), .pad_pu(pad_pu)
  );

  // R2
  cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (pad_ie == ~$past(cfg_led_en)));
  // R9
  raw_unused_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == LM_RAW) |-> (pad_oe[7:6] & en_q[7:6]) == 2'b00);
  // R11
  fdx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != LM_RAW && en_q[5] && p2_fdx) |-> pad_oe[5]);
endmodule

// File: tb/tb_gpio_led_mux.sv
`timescale 1ns/1ps
module tb_gpio_led_mux;
  localparam int unsigned ST = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] strap_mode = 2'd2, cfg_mode = 0;
  logic [7:0] strap_led_en = 8'hA5, cfg_led_en = 0;
  logic cfg_load = 0;
  logic [7:0] gpio_out = 0, gpio_oe = 0, pad_in = 0;
  logic [7:0] gpio_in, pad_out, pad_oe, pad_ie, pad_pu;
  logic p1_link = 0, p1_spd100 = 0, p1_fdx = 0, p1_col = 0, p1_act = 0, p1_txen = 0, p1_rxdv = 0;
  logic p2_link = 0, p2_spd100 = 0, p2_fdx = 0, p2_col = 0, p2_act = 0, p2_txen = 0, p2_rxdv = 0;
  logic h_rx = 0, h_tx = 0, h_txen = 0, h_rxdv = 0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [1:0] m_mode;
  logic [7:0] m_en;
  int m_cnt [6];

  always #4 clk = ~clk;

  gpio_led_mux #(.STRETCH_CYC(ST)) dut (.*);

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit sa(int i);
    return m_cnt[i] != 0;
  endfunction

  function automatic logic [3:0] side(logic [1:0] md, logic lk, logic sp, logic fd,
                                      logic cs, logic as, logic tx, logic rv,
                                      logic hs, logic h3, logic l3);
    logic la;
    la = lk && !as;
    case (md)
      2'd0: return {hs, la, fd || cs, sp};
      2'd1: return {hs, sp && la, fd || cs, !sp && la};
      2'd2: return {as, lk, fd || cs, sp};
      default: return {h3, l3, tx, rv};
    endcase
  endfunction

  function automatic logic [7:0] exp_on();
    return {side(m_mode, p2_link, p2_spd100, p2_fdx, sa(3), sa(2), p2_txen, p2_rxdv, sa(4), 1'b0, 1'b0),
            side(m_mode, p1_link, p1_spd100, p1_fdx, sa(1), sa(0), p1_txen, p1_rxdv, sa(5), h_txen, h_rxdv)};
  endfunction

  function automatic string mreq();
    case (m_mode)
      2'd0: return "R6/R10/R11";
      2'd1: return "R7/R10/R11";
      2'd2: return "R8/R11";
      default: return "R9";
    endcase
  endfunction

  task automatic check_all();
    logic [7:0] on;
    on = exp_on();
    cmp("R3/R4 pad_ie", pad_ie, ~m_en);
    cmp("R3/R4 pad_pu", pad_pu, ~m_en);
    cmp("R3/R4 pad_out", pad_out, gpio_out & ~m_en);
    cmp("R3/R4 gpio_in", gpio_in, pad_in & ~m_en);
    cmp({mreq(), " R4 pad_oe"}, pad_oe, (gpio_oe & ~m_en) | (on & m_en));
  endtask

  // one clock: model update at the edge, check at the falling edge
  task automatic step();
    @(posedge clk);
    if (cfg_load) begin m_mode = cfg_mode; m_en = cfg_led_en; end
    begin
      logic [5:0] p;
      p = {h_tx, h_rx, p2_col, p2_act, p1_col, p1_act};
      for (int i = 0; i < 6; i++)
        if (p[i]) m_cnt[i] = ST; else if (m_cnt[i] > 0) m_cnt[i]--;
    end
    @(negedge clk);
    cfg_load = 0;
    check_all();
  endtask

  task automatic rand_in(int pulse_pct);
    {p1_link, p1_spd100, p1_fdx, p1_txen, p1_rxdv} = 5'($urandom);
    {p2_link, p2_spd100, p2_fdx, p2_txen, p2_rxdv} = 5'($urandom);
    {h_txen, h_rxdv} = 2'($urandom);
    p1_act = ($urandom % 100) < pulse_pct; p1_col = ($urandom % 100) < pulse_pct;
    p2_act = ($urandom % 100) < pulse_pct; p2_col = ($urandom % 100) < pulse_pct;
    h_rx   = ($urandom % 100) < pulse_pct; h_tx   = ($urandom % 100) < pulse_pct;
    gpio_out = 8'($urandom); gpio_oe = 8'($urandom); pad_in = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 6; i++) m_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_mode = 2'd2; m_en = 8'hA5;
    strap_mode = 2'd0; strap_led_en = 8'h00;   // R1: changing straps after reset
    check_all();
    cmp("R1 strap enables", pad_ie, ~8'hA5);
    step();
    cmp("R1 straps ignored after reset", pad_pu, ~8'hA5);

    // directed R11: half duplex, collision pulse then expiry
    cfg_load = 1; cfg_mode = 2'd0; cfg_led_en = 8'hFF;
    step();
    cmp("R2 load", pad_ie, 8'h00);
    p2_fdx = 0; p2_col = 1; step(); p2_col = 0;
    cmp("R11 col on", {7'd0, pad_oe[5]}, 8'd1);
    repeat (ST) step();
    cmp("R11 col expired / R5", {7'd0, pad_oe[5]}, 8'd0);
    // directed R10: link with activity blink
    p1_link = 1; p1_act = 1; step(); p1_act = 0;
    cmp("R10 blink off", {7'd0, pad_oe[2]}, 8'd0);
    repeat (ST) step();
    cmp("R10 back on / R5", {7'd0, pad_oe[2]}, 8'd1);

    for (int md = 0; md < 4; md++) begin
      cfg_load = 1; cfg_mode = 2'(md); cfg_led_en = 8'hFF;
      step();
      for (int k = 0; k < 400; k++) begin
        rand_in(8);
        if (k % 97 == 50) begin cfg_load = 1; cfg_mode = 2'(md); cfg_led_en = 8'($urandom); end
        step();
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule